// File: doc/BRIEF.md
# Random Number Generator Register Front End

This block is the memory-mapped face of a random number generator. A single-cycle read/write strobe port selects one of four 32-bit word registers: a control word, a status word, an entropy input and a one-word output buffer. While generation is enabled and the block is awake, an internal 32-bit LFSR runs for a fixed number of cycles and then deposits its state into the output buffer. The buffer holds one word at a time, and a read consumes that word.

Software reads status to learn whether a word is waiting. Reading the output while the buffer is empty is an error event. It returns zero and sets three status flags, and each of those flags clears in its own way. If assurance reporting is on, the same event also latches a security-violation flag that only a block reset removes. The enable and assurance controls can only be switched on. Software writes to the entropy register XOR new words into the LFSR state. An active-high interrupt line reports the error flag unless the mask bit is set.

Top module: `rng_regif`

## Requirements
- R1: After reset, control reads 0x00000000, status reads 0x00010000 (output size field [23:16] equal to 1, all flags and the level clear) and the interrupt output is low.
- R2: Control bit 0 (enable) and bit 1 (assurance) stay at 1 after a later write of 0 until reset. Bit 2 (mask) and bit 4 (sleep) read back as last written. Bit 3 (clear) always reads 0.
- R3: With enable set, awake and the buffer empty, the status level field [15:8] becomes 1 exactly GEN_CYCLES (default 32) clock edges after the edge that accepts the enabling write.
- R4: An output read (offset 0xC) with level 1 returns the stored nonzero word and leaves level 0. A refilled word differs from the one before it.
- R5: An output read with level 0 returns zero and sets status bit 1 (last read underflow), bit 2 (underflow since last status read) and bit 3 (error). With mask clear, the interrupt output goes high on the second edge after the read.
- R6: A status read (offset 0x4) clears status bits 1 and 2 and leaves bit 3 unchanged.
- R7: Writing control with bit 3 set clears status bit 3, and the interrupt output falls one edge later.
- R8: While control bit 2 is set, the interrupt output stays low although status bit 3 is set. Clearing the mask raises the interrupt.
- R9: Status bit 0 (security violation) is set by an underflow read only when assurance is on. Once set, it survives status reads and error clears.
- R10: Status bit 4 is set when control bit 4 is set or the doze input is high. No word is generated while it is set, and generation resumes when both are clear.
- R11: Reads of the entropy register (offset 0x8) return zero. A word written there is XORed into the LFSR state (a zero result is replaced by the seed), so it changes the words that follow.
- R12: The level never exceeds 1. While the buffer is full, its word is held unchanged until it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 4 | Byte address. Word aligned; unaligned accesses select nothing |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally during bus_rd |
| doze_i | input | 1 | External request to enter sleep |
| irq_o | output | 1 | Registered error interrupt, active high |

## Verification
A corrupted level or counter shows up at the status level field. The fill latency moves off the exact edge count, a second word appears without a read, or an empty read returns data instead of zero. Any of these is visible on the first status or output read after the fault. A wrong flag is visible on the next status read. Flags that should have cleared stay set, and sticky bits drop after an error clear or a status read. A wrong mask or error path appears on irq_o within two edges of the triggering read or write.

// File: rtl/rng_pkg.sv
package rng_pkg;
   localparam int ADDR_W   = 4;
   localparam int REG_W    = 32;
   localparam int OUT_SIZE = 1;

   // word register index taken from address bits [3:2]
   typedef enum logic [1:0] {
      RIDX_CTRL = 2'd0,
      RIDX_STAT = 2'd1,
      RIDX_ENT  = 2'd2,
      RIDX_OUT  = 2'd3
   } reg_idx_e;

   // control bit positions
   localparam int CB_EN    = 0;
   localparam int CB_HA    = 1;
   localparam int CB_MASK  = 2;
   localparam int CB_CLR   = 3;
   localparam int CB_SLEEP = 4;

   // status bit positions
   localparam int SB_SECV  = 0;
   localparam int SB_LRS   = 1;
   localparam int SB_UNDR  = 2;
   localparam int SB_ERR   = 3;
   localparam int SB_SLEEP = 4;
   localparam int SB_LVL_LO  = 8;
   localparam int SB_SIZE_LO = 16;

   typedef struct packed {
      logic sleep;
      logic mask;
      logic assure;
      logic enable;
   } ctrl_t;
endpackage

// File: rtl/rng_ctrl.sv
module rng_ctrl
   import rng_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_ctrl,
   input  logic [4:0] wbits,
   output ctrl_t      ctrl_q,
   output logic       clr_pulse
);
   // enable and assurance only accumulate ones; reset is the sole way down
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q.enable <= ctrl_q.enable | wbits[CB_EN];
         ctrl_q.assure <= ctrl_q.assure | wbits[CB_HA];
         ctrl_q.mask   <= wbits[CB_MASK];
         ctrl_q.sleep  <= wbits[CB_SLEEP];
      end
   end

   assign clr_pulse = wr_ctrl & wbits[CB_CLR];
endmodule

// File: rtl/rng_flags.sv
module rng_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic out_rd,
   input  logic underflow,
   input  logic stat_rd,
   input  logic clr_err,
   input  logic assure,
   input  logic mask,
   output logic secv_q,
   output logic lrs_q,
   output logic undr_q,
   output logic err_q,
   output logic irq_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         secv_q <= 1'b0;
         lrs_q  <= 1'b0;
         undr_q <= 1'b0;
         err_q  <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         // last-read flag follows every output read, cleared by status read
         if (out_rd)       lrs_q <= underflow;
         else if (stat_rd) lrs_q <= 1'b0;

         if (underflow)    undr_q <= 1'b1;
         else if (stat_rd) undr_q <= 1'b0;

         // a new error wins over a simultaneous clear
         if (underflow)    err_q <= 1'b1;
         else if (clr_err) err_q <= 1'b0;

         if (underflow && assure) secv_q <= 1'b1;

         irq_q <= err_q & ~mask;
      end
   end
endmodule

// File: rtl/rng_engine.sv
module rng_engine #(
   parameter int              W          = 32,
   parameter int              GEN_CYCLES = 32,
   parameter bit              FIBONACCI  = 1'b0,
   parameter logic [W-1:0]    TAPS       = 32'h8020_0003,
   parameter logic [W-1:0]    SEED       = 32'h1ACE_B00C
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_ok,
   input  logic         ent_wr,
   input  logic [W-1:0] ent_data,
   input  logic         take,
   output logic         level_q,
   output logic [W-1:0] word_q
);
   localparam int CW = $clog2(GEN_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(GEN_CYCLES - 1);

   logic [W-1:0]  state_q;
   logic [W-1:0]  state_nx;
   logic [W-1:0]  mixed;
   logic [CW-1:0] cnt_q;
   logic          running;
   logic          load;

   generate
      if (FIBONACCI) begin : g_fib
         assign state_nx = {state_q[W-2:0], ^(state_q & TAPS)};
      end else begin : g_gal
         assign state_nx = (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
      end
   endgenerate

   assign mixed   = ((state_q ^ ent_data) == '0) ? SEED : (state_q ^ ent_data);
   assign running = run_ok & ~level_q;
   assign load    = running & (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEED;
      end else if (ent_wr) begin
         state_q <= mixed;
      end else if (running) begin
         state_q <= state_nx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!running || load) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0;
         word_q  <= '0;
      end else if (load) begin
         level_q <= 1'b1;
         word_q  <= state_nx;
      end else if (take) begin
         level_q <= 1'b0;
         word_q  <= '0;
      end
   end
endmodule

// File: rtl/rng_regif.sv
module rng_regif
   import rng_pkg::*;
#(
   parameter int                 DATA_W     = 32,
   parameter int                 GEN_CYCLES = 32,
   parameter bit                 FIBONACCI  = 1'b0,
   parameter logic [DATA_W-1:0]  TAPS       = 32'h8020_0003,
   parameter logic [DATA_W-1:0]  SEED       = 32'h1ACE_B00C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [3:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              doze_i,
   output logic              irq_o
);
   generate
      if (DATA_W != REG_W) begin : g_bad_width
         $error("rng_regif: DATA_W must equal 32");
      end
      if (GEN_CYCLES < 1) begin : g_bad_cycles
         $error("rng_regif: GEN_CYCLES must be at least 1");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("rng_regif: SEED must be nonzero");
      end
   endgenerate

   ctrl_t             ctl;
   logic              ctl_en, ctl_ha, ctl_mask;
   logic              clr_pulse;
   logic              aligned;
   reg_idx_e          ridx;
   logic              wr_ctrl, wr_ent, rd_stat, rd_out;
   logic              sleeping;
   logic              eng_lvl;
   logic [DATA_W-1:0] eng_word;
   logic              underflow;
   logic              fl_secv, fl_lrs, fl_undr, fl_err;
   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] ctrl_word;

   // address decode: aligned word accesses only
   assign aligned = (bus_addr[1:0] == 2'b00);
   assign ridx    = reg_idx_e'(bus_addr[3:2]);
   assign wr_ctrl = bus_wr & aligned & (ridx == RIDX_CTRL);
   assign wr_ent  = bus_wr & aligned & (ridx == RIDX_ENT);
   assign rd_stat = bus_rd & aligned & (ridx == RIDX_STAT);
   assign rd_out  = bus_rd & aligned & (ridx == RIDX_OUT);

   rng_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (wr_ctrl),
      .wbits     (bus_wdata[4:0]),
      .ctrl_q    (ctl),
      .clr_pulse (clr_pulse)
   );

   assign ctl_en   = ctl.enable;
   assign ctl_ha   = ctl.assure;
   assign ctl_mask = ctl.mask;
   assign sleeping = ctl.sleep | doze_i;

   rng_engine #(
      .W          (DATA_W),
      .GEN_CYCLES (GEN_CYCLES),
      .FIBONACCI  (FIBONACCI),
      .TAPS       (TAPS),
      .SEED       (SEED)
   ) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_ok   (ctl_en & ~sleeping),
      .ent_wr   (wr_ent),
      .ent_data (bus_wdata),
      .take     (rd_out & eng_lvl),
      .level_q  (eng_lvl),
      .word_q   (eng_word)
   );

   assign underflow = rd_out & ~eng_lvl;

   rng_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .out_rd    (rd_out),
      .underflow (underflow),
      .stat_rd   (rd_stat),
      .clr_err   (clr_pulse),
      .assure    (ctl_ha),
      .mask      (ctl_mask),
      .secv_q    (fl_secv),
      .lrs_q     (fl_lrs),
      .undr_q    (fl_undr),
      .err_q     (fl_err),
      .irq_q     (irq_o)
   );

   always_comb begin
      stat_word = '0;
      stat_word[SB_SECV]  = fl_secv;
      stat_word[SB_LRS]   = fl_lrs;
      stat_word[SB_UNDR]  = fl_undr;
      stat_word[SB_ERR]   = fl_err;
      stat_word[SB_SLEEP] = sleeping;
      stat_word[SB_LVL_LO +: 8]  = {7'b0, eng_lvl};
      stat_word[SB_SIZE_LO +: 8] = 8'(OUT_SIZE);
   end

   always_comb begin
      ctrl_word = '0;
      ctrl_word[CB_EN]    = ctl.enable;
      ctrl_word[CB_HA]    = ctl.assure;
      ctrl_word[CB_MASK]  = ctl.mask;
      ctrl_word[CB_SLEEP] = ctl.sleep;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd && aligned) begin
         unique case (ridx)
            RIDX_CTRL: bus_rdata = ctrl_word;
            RIDX_STAT: bus_rdata = stat_word;
            RIDX_ENT:  bus_rdata = '0;
            RIDX_OUT:  bus_rdata = eng_lvl ? eng_word : '0;
            default:   bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/rng_regif_chk.sv
module rng_regif_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_wr,
   input logic        bus_rd,
   input logic [3:0]  bus_addr,
   input logic        clr_bit,
   input logic [31:0] bus_rdata,
   input logic        irq_o,
   input logic        ctl_en,
   input logic        ctl_ha,
   input logic        ctl_mask,
   input logic        fl_secv,
   input logic        fl_err,
   input logic        fl_undr,
   input logic        eng_lvl,
   input logic [31:0] eng_word
);
   logic out_rd, ent_rd, ctrl_wr;
   assign out_rd  = bus_rd && (bus_addr == 4'hC);
   assign ent_rd  = bus_rd && (bus_addr == 4'h8);
   assign ctrl_wr = bus_wr && (bus_addr == 4'h0);

   p_en_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_en |=> ctl_en);
   p_ha_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_ha |=> ctl_ha);
   p_take_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_rd && eng_lvl |=> !eng_lvl && eng_word == 32'h0);
   p_uf_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_rd && !eng_lvl |=> fl_err && fl_undr);
   p_uf_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_rd && !eng_lvl |-> bus_rdata == 32'h0);
   p_uf_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_rd && !eng_lvl && !ctl_mask && !bus_wr |=> ##1 irq_o);
   p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && clr_bit && !out_rd |=> !fl_err);
   p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctl_mask) |-> !irq_o);
   p_secv_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fl_secv |=> fl_secv);
   p_secv_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_secv) |-> $past(ctl_ha) && $past(out_rd));
   p_ent_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ent_rd |-> bus_rdata == 32'h0);
   p_full_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      eng_lvl && !out_rd |=> eng_lvl && $stable(eng_word));
endmodule

bind rng_regif rng_regif_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .clr_bit   (bus_wdata[3]),
   .bus_rdata (bus_rdata),
   .irq_o     (irq_o),
   .ctl_en    (ctl_en),
   .ctl_ha    (ctl_ha),
   .ctl_mask  (ctl_mask),
   .fl_secv   (fl_secv),
   .fl_err    (fl_err),
   .fl_undr   (fl_undr),
   .eng_lvl   (eng_lvl),
   .eng_word  (eng_word)
);

// File: tb/rng_regif_tb.sv
`timescale 1ns/1ps
module rng_regif_tb;
   localparam logic [3:0] A_CTRL = 4'h0;
   localparam logic [3:0] A_STAT = 4'h4;
   localparam logic [3:0] A_ENT  = 4'h8;
   localparam logic [3:0] A_OUT  = 4'hC;
   localparam int         GEN    = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        doze_i = 1'b0;
   logic        irq_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rng_regif #(.GEN_CYCLES(GEN)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .doze_i(doze_i), .irq_o(irq_o)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, w_a, w_b;
      int found;

      // reset state
      do_reset();
      rd(A_CTRL, v); check(v == 32'h0, "R1 ctrl reset", v, 32'h0);
      rd(A_STAT, v); check(v == 32'h0001_0000, "R1 status reset", v, 32'h0001_0000);
      check(irq_o == 1'b0, "R1 irq reset", {31'b0, irq_o}, 32'h0);
      rd(A_ENT, v);  check(v == 32'h0, "R11 entropy reads zero", v, 32'h0);

      // fill latency, consume, underflow, flag clearing
      wr(A_CTRL, 32'h1);
      found = -1;
      for (int i = 0; i < GEN + 8; i++) begin
         rd(A_STAT, v);
         if (v[8] && found < 0) found = i;
      end
      check(found == GEN, "R3 fill latency", found, GEN);
      check(v[15:8] == 8'd1, "R12 level capped at one", {24'b0, v[15:8]}, 32'h1);
      rd(A_OUT, w_a);
      check(w_a != 32'h0, "R4 word nonzero", w_a, 32'h1);
      rd(A_OUT, v);
      check(v == 32'h0, "R5 underflow returns zero", v, 32'h0);
      rd(A_STAT, v);
      check(v[4:0] == 5'b01110, "R5 underflow flags", {27'b0, v[4:0]}, 32'hE);
      check(v[15:8] == 8'd0, "R4 level cleared by read", {24'b0, v[15:8]}, 32'h0);
      check(irq_o == 1'b1, "R5 irq raised", {31'b0, irq_o}, 32'h1);
      rd(A_STAT, v);
      check(v[3:0] == 4'b1000, "R6 status read clears bits 1,2", {28'b0, v[3:0]}, 32'h8);
      wr(A_CTRL, 32'h9);
      idle(2);
      check(irq_o == 1'b0, "R7 irq dropped", {31'b0, irq_o}, 32'h0);
      rd(A_STAT, v);
      check(v[3] == 1'b0, "R7 error cleared", {31'b0, v[3]}, 32'h0);
      idle(GEN + 8);
      rd(A_OUT, w_b);
      check(w_b != 32'h0 && w_b != w_a, "R4 next word differs", w_b, ~w_a);

      // mask, assurance, sticky control
      do_reset();
      wr(A_CTRL, 32'h4);
      rd(A_OUT, v);
      idle(3);
      check(irq_o == 1'b0, "R8 masked irq low", {31'b0, irq_o}, 32'h0);
      rd(A_STAT, v);
      check(v[3] == 1'b1, "R8 error set while masked", {31'b0, v[3]}, 32'h1);
      check(v[0] == 1'b0, "R9 no violation without assurance", {31'b0, v[0]}, 32'h0);
      wr(A_CTRL, 32'h0);
      idle(2);
      check(irq_o == 1'b1, "R8 unmask raises irq", {31'b0, irq_o}, 32'h1);
      wr(A_CTRL, 32'h2);
      wr(A_CTRL, 32'h0);
      rd(A_CTRL, v);
      check(v == 32'h2, "R2 assurance sticky", v, 32'h2);
      rd(A_OUT, v);
      rd(A_STAT, v);
      check(v[0] == 1'b1, "R9 violation set", {31'b0, v[0]}, 32'h1);
      wr(A_CTRL, 32'h8);
      rd(A_STAT, v);
      rd(A_STAT, v);
      check(v[0] == 1'b1 && v[3] == 1'b0, "R9 violation sticky", {28'b0, v[3:0]}, 32'h1);
      wr(A_CTRL, 32'h1F);
      rd(A_CTRL, v);
      check(v == 32'h17, "R2 clear bit reads zero", v, 32'h17);
      wr(A_CTRL, 32'h0);
      rd(A_CTRL, v);
      check(v == 32'h3, "R2 enable sticky, mask/sleep follow", v, 32'h3);

      // sleep by doze and by control bit
      do_reset();
      doze_i = 1'b1;
      wr(A_CTRL, 32'h1);
      rd(A_STAT, v);
      check(v[4] == 1'b1, "R10 doze sets sleep", {31'b0, v[4]}, 32'h1);
      idle(2 * GEN);
      rd(A_STAT, v);
      check(v[15:8] == 8'd0, "R10 no fill under doze", {24'b0, v[15:8]}, 32'h0);
      doze_i = 1'b0;
      wr(A_CTRL, 32'h11);
      rd(A_STAT, v);
      check(v[4] == 1'b1, "R10 control sleep", {31'b0, v[4]}, 32'h1);
      idle(2 * GEN);
      rd(A_STAT, v);
      check(v[15:8] == 8'd0, "R10 no fill under sleep bit", {24'b0, v[15:8]}, 32'h0);
      wr(A_CTRL, 32'h01);
      idle(GEN + 8);
      rd(A_STAT, v);
      check(v[4] == 1'b0 && v[15:8] == 8'd1, "R10 resume after wake", v, 32'h0001_0100);

      // determinism, hold while full, entropy effect
      do_reset();
      wr(A_CTRL, 32'h1);
      idle(GEN + 100);
      rd(A_OUT, v);
      check(v == w_a, "R12 word held while full", v, w_a);
      do_reset();
      wr(A_ENT, 32'h5A5A_1234);
      wr(A_CTRL, 32'h1);
      idle(GEN + 8);
      rd(A_OUT, v);
      check(v != w_a && v != 32'h0, "R11 entropy changes word", v, ~w_a);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule